// File: doc/BRIEF.md
# CAN Interrupt Source Aggregator

This block sits beside a CAN protocol engine and turns its raw event pulses into interrupt requests. Six event classes are tracked: successful transmission, valid reception, error-state change, protocol error, arbitration loss and wakeup from sleep. Each one sets its own sticky status bit. A per-source enable bit gates each status bit onto one of four request lines. The three error-related sources share a single line, so software reads the status register to tell them apart.

Transmit and receive events arrive as one pulse per message buffer. A buffer's pulse counts only while that buffer's own enable bit is set. Wakeup is found by passing the receive pin through a synchronizer and looking for a falling edge, meaning a recessive-to-dominant transition, while the sleep input is high. Software uses a small register port to program the source enables and buffer enables, and to clear status bits by writing ones to them.

Top module: `can_irq_aggregator`

## Requirements
- R1: After reset, the status bits, source enable bits, buffer enable bits and all four request lines are 0.
- R2: Status bit 0 is set one clock after a `tx_done_i` pulse on any buffer whose enable bit, at register address 2 (bit b for buffer b), is 1. Pulses on buffers whose enable bit is 0 do not set it.
- R3: Status bit 1 is set one clock after an `rx_valid_i` pulse on any buffer whose enable bit is 1. Pulses on disabled buffers do not set it.
- R4: Status bit 2 is set when `err_state_i` (0 error active, 1 warning level, 2 error passive, 3 bus-off) changes to a nonzero value. It is not set when the value holds or changes to 0.
- R5: Status bit 3 is set by a pulse on any of the five `proto_err_i` bits (stuff, form, ACK, bit, CRC).
- R6: Status bit 4 is set by an `arb_lost_i` pulse.
- R7: Status bit 5 is set when `can_rx_i` falls from 1 to 0 while `sleep_i` is 1, after a two-flop synchronizer and an edge register. The status bit shows it three clocks after the pin falls. A fall while `sleep_i` is 0 has no effect.
- R8: Status bits are sticky. A write to address 0 clears exactly the bits written as 1 and leaves the others unchanged.
- R9: When a source event and a clear of the same bit happen in the same cycle, the bit ends up set.
- R10: `irq_tx_o` = st[0]&en[0]; `irq_rx_o` = st[1]&en[1]; `irq_err_o` = OR of st[k]&en[k] for k = 2, 3, 4; `irq_wake_o` = st[5]&en[5]. Each line is a level and changes in the same cycle as the status or enable bit.
- R11: Reads return status at address 0, source enables at address 1 and buffer enables at address 2, zero-extended, and 0 at address 3. A write to address 1 keeps only bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_done_i | input | NBUF | Per-buffer transmit-complete pulses |
| rx_valid_i | input | NBUF | Per-buffer valid-reception pulses |
| err_state_i | input | 2 | Current error state code |
| proto_err_i | input | 5 | Protocol error pulses: stuff, form, ACK, bit, CRC |
| arb_lost_i | input | 1 | Arbitration loss pulse |
| sleep_i | input | 1 | High while the controller is in sleep mode |
| can_rx_i | input | 1 | CAN receive pin, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address for read and write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| status_o | output | 6 | Sticky status bits |
| enable_o | output | 6 | Source enable bits |
| irq_tx_o | output | 1 | Transmit request line |
| irq_rx_o | output | 1 | Receive request line |
| irq_err_o | output | 1 | Shared error request line |
| irq_wake_o | output | 1 | Wakeup request line |

## Verification
The hardest case to reach is a source event that lands in the same cycle as a software clear of its own bit. The bench sets up the write-one-to-clear strobe and the event pulse at the same falling edge, so both arrive at one rising edge. A second hard case is buffer gating across all 16 buffers. For each buffer, the bench fires every other buffer with only that one enabled, and then fires that buffer alone with only it disabled. Wakeup is checked with the pin falling both inside and outside sleep, and the bench waits out the synchronizer delay before it samples.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
   localparam int unsigned NSRC   = 6;
   localparam int unsigned NLINE  = 4;
   localparam int unsigned NPERR  = 5;

   typedef enum logic [2:0] {
      SRC_TX   = 3'd0,
      SRC_RX   = 3'd1,
      SRC_EST  = 3'd2,
      SRC_PERR = 3'd3,
      SRC_ARB  = 3'd4,
      SRC_WAKE = 3'd5
   } src_idx_e;

   typedef enum logic [1:0] {
      EST_ACTIVE  = 2'd0,
      EST_WARNING = 2'd1,
      EST_PASSIVE = 2'd2,
      EST_BUSOFF  = 2'd3
   } err_state_e;

   localparam logic [1:0] ADR_STATUS = 2'd0;
   localparam logic [1:0] ADR_SRCEN  = 2'd1;
   localparam logic [1:0] ADR_BUFEN  = 2'd2;

   // Which status bits feed each request line: tx, rx, err, wake.
   localparam logic [NLINE-1:0][NSRC-1:0] LINE_MASK = {
      6'b100000,
      6'b011100,
      6'b000010,
      6'b000001
   };
endpackage

// File: rtl/can_irq_buf_gate.sv
module can_irq_buf_gate #(
   parameter int unsigned NBUF = 16
) (
   input  logic [NBUF-1:0] tx_done_i,
   input  logic [NBUF-1:0] rx_valid_i,
   input  logic [NBUF-1:0] buf_en_i,
   output logic            tx_evt_o,
   output logic            rx_evt_o
);
   logic [NBUF-1:0] tx_hit;
   logic [NBUF-1:0] rx_hit;

   for (genvar b = 0; b < NBUF; b++) begin : g_buf
      assign tx_hit[b] = tx_done_i[b]  & buf_en_i[b];
      assign rx_hit[b] = rx_valid_i[b] & buf_en_i[b];
   end

   assign tx_evt_o = |tx_hit;
   assign rx_evt_o = |rx_hit;
endmodule

// File: rtl/can_irq_wake_det.sv
module can_irq_wake_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sleep_i,
   input  logic rx_pin_i,
   output logic wake_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '1;
         last_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_pin_i};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign wake_o = sleep_i & last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/can_irq_err_det.sv
module can_irq_err_det
   import can_irq_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] err_state_i,
   input  logic [NPERR-1:0] proto_err_i,
   output logic       est_evt_o,
   output logic       perr_evt_o
);
   logic [1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= EST_ACTIVE;
      else         prev_q <= err_state_i;
   end

   assign est_evt_o  = (err_state_i != prev_q) && (err_state_i != EST_ACTIVE);
   assign perr_evt_o = |proto_err_i;
endmodule

// File: rtl/can_irq_status_reg.sv
module can_irq_status_reg #(
   parameter int unsigned WIDTH = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] status_o
);
   logic [WIDTH-1:0] status_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q <= '0;
      else         status_q <= (status_q & ~clr_i) | set_i;
   end

   assign status_o = status_q;

   // R8: a set bit that is not cleared stays set
   a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((status_q & ~clr_i) != '0) |=>
      ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i)));

   // R9: an event wins over a same-cycle clear
   a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/can_irq_line_map.sv
module can_irq_line_map
   import can_irq_pkg::*;
(
   input  logic [NSRC-1:0]  status_i,
   input  logic [NSRC-1:0]  enable_i,
   output logic [NLINE-1:0] irq_o
);
   logic [NSRC-1:0] pending;
   assign pending = status_i & enable_i;

   for (genvar g = 0; g < NLINE; g++) begin : g_line
      assign irq_o[g] = |(pending & LINE_MASK[g]);
   end
endmodule

// File: rtl/can_irq_aggregator.sv
module can_irq_aggregator
   import can_irq_pkg::*;
#(
   parameter int unsigned NBUF        = 16,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NBUF-1:0]   tx_done_i,
   input  logic [NBUF-1:0]   rx_valid_i,
   input  logic [1:0]        err_state_i,
   input  logic [4:0]        proto_err_i,
   input  logic              arb_lost_i,
   input  logic              sleep_i,
   input  logic              can_rx_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic [5:0]        status_o,
   output logic [5:0]        enable_o,
   output logic              irq_tx_o,
   output logic              irq_rx_o,
   output logic              irq_err_o,
   output logic              irq_wake_o
);
   if (NBUF < 1 || NBUF > DATA_W) begin : g_bad_nbuf
      $error("NBUF must be between 1 and DATA_W");
   end
   if (DATA_W < NSRC) begin : g_bad_dw
      $error("DATA_W must hold all status bits");
   end
   if (ADDR_W < 2) begin : g_bad_aw
      $error("ADDR_W must be at least 2");
   end

   logic [NSRC-1:0]  src_en_q;
   logic [NBUF-1:0]  buf_en_q;
   logic [NSRC-1:0]  status_q;
   logic [NSRC-1:0]  set_vec;
   logic [NSRC-1:0]  clr_vec;
   logic [NLINE-1:0] irq_vec;
   logic             tx_evt, rx_evt, est_evt, perr_evt, wake_evt;
   logic             wr_status, wr_srcen, wr_bufen;

   assign wr_status = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_STATUS));
   assign wr_srcen  = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_SRCEN));
   assign wr_bufen  = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_BUFEN));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         src_en_q <= '0;
         buf_en_q <= '0;
      end else begin
         if (wr_srcen) src_en_q <= reg_wdata_i[NSRC-1:0];
         if (wr_bufen) buf_en_q <= reg_wdata_i[NBUF-1:0];
      end
   end

   can_irq_buf_gate #(.NBUF(NBUF)) u_buf_gate (
      .tx_done_i (tx_done_i),
      .rx_valid_i(rx_valid_i),
      .buf_en_i  (buf_en_q),
      .tx_evt_o  (tx_evt),
      .rx_evt_o  (rx_evt)
   );

   can_irq_err_det u_err_det (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .err_state_i(err_state_i),
      .proto_err_i(proto_err_i),
      .est_evt_o  (est_evt),
      .perr_evt_o (perr_evt)
   );

   can_irq_wake_det #(.SYNC_STAGES(SYNC_STAGES)) u_wake_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sleep_i (sleep_i),
      .rx_pin_i(can_rx_i),
      .wake_o  (wake_evt)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[SRC_TX]   = tx_evt;
      set_vec[SRC_RX]   = rx_evt;
      set_vec[SRC_EST]  = est_evt;
      set_vec[SRC_PERR] = perr_evt;
      set_vec[SRC_ARB]  = arb_lost_i;
      set_vec[SRC_WAKE] = wake_evt;
   end

   assign clr_vec = wr_status ? reg_wdata_i[NSRC-1:0] : '0;

   can_irq_status_reg #(.WIDTH(NSRC)) u_status (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_vec),
      .clr_i   (clr_vec),
      .status_o(status_q)
   );

   can_irq_line_map u_line_map (
      .status_i(status_q),
      .enable_i(src_en_q),
      .irq_o   (irq_vec)
   );

   always_comb begin
      case (reg_addr_i)
         ADDR_W'(ADR_STATUS): reg_rdata_o = DATA_W'(status_q);
         ADDR_W'(ADR_SRCEN):  reg_rdata_o = DATA_W'(src_en_q);
         ADDR_W'(ADR_BUFEN):  reg_rdata_o = DATA_W'(buf_en_q);
         default:             reg_rdata_o = '0;
      endcase
   end

   assign status_o   = status_q;
   assign enable_o   = src_en_q;
   assign irq_tx_o   = irq_vec[0];
   assign irq_rx_o   = irq_vec[1];
   assign irq_err_o  = irq_vec[2];
   assign irq_wake_o = irq_vec[3];

   // R10: a request line needs a pending, enabled source
   a_r10_tx_needs_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_tx_o |-> (status_q[SRC_TX] && src_en_q[SRC_TX]));
   a_r10_err_needs_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_err_o |-> ((status_q[4:2] & src_en_q[4:2]) != 3'b000));

   // R2: transmit status only rises after an enabled buffer event
   a_r2_tx_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_q[SRC_TX]) |-> $past(|(tx_done_i & buf_en_q)));

   // R7: wakeup status only rises while asleep
   a_r7_wake_in_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_q[SRC_WAKE]) |-> $past(sleep_i));
endmodule

// File: tb/can_irq_aggregator_tb.sv
module can_irq_aggregator_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NBUF = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NBUF-1:0] tx_done = '0, rx_valid = '0;
   logic [1:0]  err_state = 2'd0;
   logic [4:0]  proto_err = '0;
   logic        arb_lost = 1'b0, sleep = 1'b0, can_rx = 1'b1;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [5:0]  status, enable;
   logic        irq_tx, irq_rx, irq_err, irq_wake;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_irq_aggregator u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .tx_done_i(tx_done), .rx_valid_i(rx_valid),
      .err_state_i(err_state), .proto_err_i(proto_err),
      .arb_lost_i(arb_lost), .sleep_i(sleep), .can_rx_i(can_rx),
      .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata), .status_o(status), .enable_o(enable),
      .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .irq_err_o(irq_err), .irq_wake_o(irq_wake)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
   endtask

   task automatic lines_chk(input string req);
      logic [3:0] exp;
      exp[0] = status[0] & enable[0];
      exp[1] = status[1] & enable[1];
      exp[2] = |(status[4:2] & enable[4:2]);
      exp[3] = status[5] & enable[5];
      chk(req, {irq_wake, irq_err, irq_rx, irq_tx}, exp);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 status", status, 0);
      chk("R1 enable", enable, 0);
      reg_addr = 2'd2; #1;
      chk("R1 bufen", reg_rdata, 0);
      reg_addr = 2'd0;
      chk("R1 lines", {irq_wake, irq_err, irq_rx, irq_tx}, 0);

      // R2 transmit gating sweep
      for (int b = 0; b < NBUF; b++) begin
         wr(2'd2, 16'(1 << b));
         tx_done = ~(NBUF'(1) << b); step(); tx_done = '0;
         chk($sformatf("R2 others buf%0d", b), status[0], 0);
         tx_done = NBUF'(1) << b; step(); tx_done = '0;
         chk($sformatf("R2 own buf%0d", b), status[0], 1);
         wr(2'd0, 16'h0001);
      end
      // R3 receive gating sweep
      for (int b = 0; b < NBUF; b++) begin
         wr(2'd2, ~16'(1 << b));
         rx_valid = NBUF'(1) << b; step(); rx_valid = '0;
         chk($sformatf("R3 disabled buf%0d", b), status[1], 0);
         rx_valid = '1; step(); rx_valid = '0;
         chk($sformatf("R3 any buf%0d", b), status[1], 1);
         wr(2'd0, 16'h0002);
      end

      // R4 error state changes
      err_state = 2'd1; step();
      chk("R4 to warning", status[2], 1);
      wr(2'd0, 16'h0004); step();
      chk("R4 hold warning", status[2], 0);
      err_state = 2'd2; step();
      chk("R4 to passive", status[2], 1);
      wr(2'd0, 16'h0004);
      err_state = 2'd0; step();
      chk("R4 to active", status[2], 0);
      err_state = 2'd3; step();
      chk("R4 to busoff", status[2], 1);
      err_state = 2'd0;
      wr(2'd0, 16'h0004); step();
      chk("R4 cleared", status, 0);

      // R5 each protocol error kind
      for (int k = 0; k < 5; k++) begin
         proto_err = 5'(1 << k); step(); proto_err = '0;
         chk($sformatf("R5 kind%0d", k), status, 6'b001000);
         wr(2'd0, 16'h0008);
      end

      // R6 arbitration loss
      arb_lost = 1'b1; step(); arb_lost = 1'b0;
      chk("R6 arb", status, 6'b010000);
      wr(2'd0, 16'h0010);

      // R7 wakeup outside sleep has no effect
      sleep = 1'b0; can_rx = 1'b0;
      repeat (5) step();
      chk("R7 awake fall", status[5], 0);
      can_rx = 1'b1; repeat (4) step();
      sleep = 1'b1; can_rx = 1'b0;
      step(); step();
      chk("R7 sync delay", status[5], 0);
      step();
      chk("R7 sleep fall", status[5], 1);
      can_rx = 1'b1; repeat (4) step();
      sleep = 1'b0;
      wr(2'd0, 16'h0020);

      // R8 selective clear, R9 set wins
      arb_lost = 1'b1; proto_err = 5'b00001; step();
      arb_lost = 1'b0; proto_err = '0;
      chk("R8 both set", status, 6'b011000);
      wr(2'd0, 16'h0008);
      chk("R8 only bit3 cleared", status, 6'b010000);
      repeat (3) step();
      chk("R8 sticky", status, 6'b010000);
      wr(2'd0, 16'h0010);
      arb_lost = 1'b1; wr(2'd0, 16'h0010); arb_lost = 1'b0;
      chk("R9 set wins", status[4], 1);
      wr(2'd0, 16'h003F);
      chk("R8 all cleared", status, 0);

      // R10 line mapping: set all sources, sweep enables
      wr(2'd2, 16'hFFFF);
      tx_done = 1; rx_valid = 1; err_state = 2'd1; proto_err = 5'b10000; arb_lost = 1'b1;
      step();
      tx_done = 0; rx_valid = 0; proto_err = 0; arb_lost = 1'b0;
      sleep = 1'b1; can_rx = 1'b0; repeat (4) step(); sleep = 1'b0; can_rx = 1'b1;
      chk("R10 all status", status, 6'h3F);
      for (int e = 0; e < 64; e++) begin
         wr(2'd1, 16'(e));
         lines_chk($sformatf("R10 en%0d", e));
      end
      wr(2'd1, 16'hFFFF);
      chk("R11 enable masked", enable, 6'h3F);
      for (int k = 0; k < 6; k++) begin
         wr(2'd0, 16'(1 << k));
         lines_chk($sformatf("R10 clear%0d", k));
      end

      // R11 read port
      reg_addr = 2'd1; #1; chk("R11 read srcen", reg_rdata, 16'h003F);
      reg_addr = 2'd2; #1; chk("R11 read bufen", reg_rdata, 16'hFFFF);
      reg_addr = 2'd3; #1; chk("R11 read unused", reg_rdata, 0);
      err_state = 2'd0; step();
      reg_addr = 2'd0; #1; chk("R11 read status", reg_rdata, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule